// File: doc/BRIEF.md
# FMCW Chirp Staircase Ramp Generator

This block produces the 8-bit control code for an external resistor-ladder DAC whose voltage tunes an oscillator, so that the oscillator sweeps a linear frequency chirp. The code rises as a staircase. It starts at a programmed start code. It goes up by one LSB after each programmed dwell interval. After a programmed number of increments it snaps back to the start code. Between chirps the block sits in an idle gap of programmed length. The sweep repeats for as long as the block is enabled and out of soft reset.

The sequencer has two states. ST_IDLE is the idle gap, in which `ramp_active` is low. ST_RAMP is the staircase, in which `ramp_active` is high. There are two transitions. IDLE_TO_RAMP is taken when the idle gap has run out. RAMP_TO_IDLE is taken when the last step has dwelt its full time, or at once when the step count is zero. A soft reset or a low enable forces ST_IDLE.

One 32-bit cycle counter times both the idle gap and the step dwell. The four configuration values are captured into shadow registers while the block is held and at each RAMP_TO_IDLE transition. A new setting therefore takes effect from the next idle gap.

Top module: `chirp_ramp_gen`

## Requirements
- R1: While `soft_rst` is high, on the following cycle `ramp_code` is 0 and `ramp_active` is 0, and the counters are cleared. An asynchronous low `rst_n` does the same.
- R2: The idle gap (ST_IDLE, `ramp_active`=0) lasts max(`idle_len`,1) cycles. An `idle_len` of 0 therefore enters the ramp on the next clock.
- R3: On the IDLE_TO_RAMP transition, `ramp_active` goes to 1 and `ramp_code` is loaded with `start_code`.
- R4: With a step count S ≥ 1, the ramp shows the codes start, start+1, …, start+S in that order. Each code is held for max(`step_dwell`,1) cycles, so a dwell of 0 advances the code every clock.
- R5: After the final code has dwelt, `ramp_code` returns to the start code and `ramp_active` goes to 0. The start code is held through the following idle gap.
- R6: A step count of 0 gives a ramp of exactly one cycle at the start code, followed by ST_IDLE.
- R7: `ramp_code` saturates at 255 and never wraps, even when start + S exceeds 255.
- R8: While `enable` is low, `ramp_code` is 0 and `ramp_active` is 0 on the next cycle. Once `enable` is high again, the sequence restarts with a full idle gap that outputs code 0.
- R9: Configuration changed during a ramp does not affect that ramp. The new values govern the idle gap and ramp that follow it.
- R10: The first idle gap after soft reset or enable is released outputs code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Ramp enable; low forces code 0 and ST_IDLE |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| start_code | input | 8 | Code loaded at the start of each ramp |
| step_count | input | 8 | Number of one-LSB increments per ramp |
| step_dwell | input | 24 | Clock cycles per code step (0 acts as 1) |
| idle_len | input | 32 | Clock cycles in the idle gap (0 acts as 1) |
| ramp_code | output | 8 | Staircase code to the DAC |
| ramp_active | output | 1 | High while in ST_RAMP |

## Verification
Every output comes from a register. A change on `soft_rst` or `enable` therefore shows at the ports one edge later. The cycle in which `soft_rst` is released is already the first idle cycle. From then on, the code and state follow a schedule that is fixed cycle by cycle: max(N,1) idle cycles, then (S+1)·max(D,1) ramp cycles, or one ramp cycle when S is 0. The bench builds that schedule from the configuration and compares both outputs at every falling edge. It drives all inputs just after a falling edge, so each comparison lands a half period after the edge that produced the value.

// File: rtl/chirp_pkg.sv
package chirp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RAMP = 1'b1
    } chirp_state_e;
endpackage

// File: rtl/chirp_cfg_shadow.sv
module chirp_cfg_shadow #(
    parameter int CODE_W  = 8,
    parameter int STEP_W  = 8,
    parameter int DWELL_W = 24,
    parameter int IDLE_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [CODE_W-1:0]  start_in,
    input  logic [STEP_W-1:0]  steps_in,
    input  logic [DWELL_W-1:0] dwell_in,
    input  logic [IDLE_W-1:0]  idle_in,
    output logic [CODE_W-1:0]  start_sh,
    output logic [STEP_W-1:0]  steps_sh,
    output logic [DWELL_W-1:0] dwell_sh,
    output logic [IDLE_W-1:0]  idle_sh
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_sh <= '0;
            steps_sh <= '0;
            dwell_sh <= '0;
            idle_sh  <= '0;
        end else if (load) begin
            start_sh <= start_in;
            steps_sh <= steps_in;
            dwell_sh <= dwell_in;
            idle_sh  <= idle_in;
        end
    end
endmodule

// File: rtl/chirp_cycle_timer.sv
module chirp_cycle_timer #(
    parameter int CNT_W   = 32,
    parameter int DWELL_W = 24,
    parameter int IDLE_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               inc,
    input  logic [IDLE_W-1:0]  idle_len,
    input  logic [DWELL_W-1:0] dwell_len,
    output logic               idle_last,
    output logic               dwell_last
);
    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_next_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // A limit of zero behaves as one: the +1 makes the compare true on the first cycle.
    always_comb begin
        cnt_next_ext = EXT_W'(cnt_q) + EXT_W'(1);
        idle_last    = cnt_next_ext >= EXT_W'(idle_len);
        dwell_last   = cnt_next_ext >= EXT_W'(dwell_len);
    end
endmodule

// File: rtl/chirp_code_path.sv
module chirp_code_path #(
    parameter int CODE_W = 8,
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              inc,
    input  logic [CODE_W-1:0] start_code,
    output logic [CODE_W-1:0] code,
    output logic [STEP_W-1:0] step_idx
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic [CODE_W-1:0] code_sat_inc;

    always_comb begin
        code_sat_inc = (code == CODE_MAX) ? CODE_MAX : code + CODE_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code     <= '0;
            step_idx <= '0;
        end else if (clr) begin
            code     <= '0;
            step_idx <= '0;
        end else if (load) begin
            code     <= start_code;
            step_idx <= '0;
        end else if (inc) begin
            code     <= code_sat_inc;
            step_idx <= step_idx + STEP_W'(1);
        end
    end
endmodule

// File: rtl/chirp_ramp_gen.sv
module chirp_ramp_gen #(
    parameter int CODE_W  = 8,
    parameter int STEP_W  = 8,
    parameter int DWELL_W = 24,
    parameter int IDLE_W  = 32,
    parameter int CNT_W   = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               soft_rst,
    input  logic [CODE_W-1:0]  start_code,
    input  logic [STEP_W-1:0]  step_count,
    input  logic [DWELL_W-1:0] step_dwell,
    input  logic [IDLE_W-1:0]  idle_len,
    output logic [CODE_W-1:0]  ramp_code,
    output logic               ramp_active
);
    import chirp_pkg::*;

    chirp_state_e state_q, state_d;

    logic hold;
    logic tmr_clr, tmr_inc;
    logic code_clr, code_load, code_inc;
    logic sh_load;
    logic idle_last, dwell_last, final_step, zero_steps;

    logic [CODE_W-1:0]  start_sh;
    logic [STEP_W-1:0]  steps_sh;
    logic [DWELL_W-1:0] dwell_sh;
    logic [IDLE_W-1:0]  idle_sh;
    logic [CODE_W-1:0]  code_q;
    logic [STEP_W-1:0]  step_idx;

    chirp_cfg_shadow #(
        .CODE_W(CODE_W), .STEP_W(STEP_W), .DWELL_W(DWELL_W), .IDLE_W(IDLE_W)
    ) u_shadow (
        .clk(clk), .rst_n(rst_n), .load(sh_load),
        .start_in(start_code), .steps_in(step_count),
        .dwell_in(step_dwell), .idle_in(idle_len),
        .start_sh(start_sh), .steps_sh(steps_sh),
        .dwell_sh(dwell_sh), .idle_sh(idle_sh)
    );

    chirp_cycle_timer #(
        .CNT_W(CNT_W), .DWELL_W(DWELL_W), .IDLE_W(IDLE_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .inc(tmr_inc),
        .idle_len(idle_sh), .dwell_len(dwell_sh),
        .idle_last(idle_last), .dwell_last(dwell_last)
    );

    chirp_code_path #(
        .CODE_W(CODE_W), .STEP_W(STEP_W)
    ) u_code (
        .clk(clk), .rst_n(rst_n), .clr(code_clr), .load(code_load),
        .inc(code_inc), .start_code(start_sh),
        .code(code_q), .step_idx(step_idx)
    );

    assign hold       = soft_rst | ~enable;
    assign zero_steps = (steps_sh == '0);
    assign final_step = (step_idx == steps_sh);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_d   = state_q;
        tmr_clr   = 1'b0;
        tmr_inc   = 1'b0;
        code_clr  = 1'b0;
        code_load = 1'b0;
        code_inc  = 1'b0;
        sh_load   = 1'b0;
        if (hold) begin
            state_d  = ST_IDLE;
            tmr_clr  = 1'b1;
            code_clr = 1'b1;
            sh_load  = 1'b1;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (idle_last) begin
                        // IDLE_TO_RAMP
                        state_d   = ST_RAMP;
                        tmr_clr   = 1'b1;
                        code_load = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
                ST_RAMP: begin
                    if (zero_steps || (dwell_last && final_step)) begin
                        // RAMP_TO_IDLE: back to start code, capture new config
                        state_d   = ST_IDLE;
                        tmr_clr   = 1'b1;
                        code_load = 1'b1;
                        sh_load   = 1'b1;
                    end else if (dwell_last) begin
                        tmr_clr  = 1'b1;
                        code_inc = 1'b1;
                    end else begin
                        tmr_inc = 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        ramp_code   = code_q;
        ramp_active = (state_q == ST_RAMP);
    end
endmodule

// File: rtl/chirp_ramp_gen_checker.sv
module chirp_ramp_gen_checker #(
    parameter int CODE_W = 8,
    parameter int STEP_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              soft_rst,
    input logic [CODE_W-1:0] ramp_code,
    input logic              ramp_active,
    input logic [CODE_W-1:0] start_sh,
    input logic [STEP_W-1:0] steps_sh
);
    localparam logic [CODE_W-1:0] CODE_MAX = '1;

    logic held;
    assign held = soft_rst || !enable;

    assert_hold_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> (ramp_code == '0 && !ramp_active));

    assert_entry_loads_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_active) |-> (ramp_code == start_sh));

    assert_step_by_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && $past(ramp_active)) |->
            ({1'b0, ramp_code} == {1'b0, $past(ramp_code)} ||
             {1'b0, ramp_code} == {1'b0, $past(ramp_code)} + (CODE_W+1)'(1) ||
             ramp_code == CODE_MAX));

    assert_return_to_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ramp_active) && !$past(held)) |-> (ramp_code == $past(start_sh)));

    assert_zero_steps_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && steps_sh == '0) |=> !ramp_active);

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_active && $past(ramp_active) && $past(ramp_code) == CODE_MAX) |->
            (ramp_code == CODE_MAX));
endmodule

bind chirp_ramp_gen chirp_ramp_gen_checker #(
    .CODE_W(CODE_W), .STEP_W(STEP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
    .ramp_code(ramp_code), .ramp_active(ramp_active),
    .start_sh(start_sh), .steps_sh(steps_sh)
);

// File: tb/chirp_ramp_gen_bench.sv
`timescale 1ns/1ps
module chirp_ramp_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b1;
    logic        soft_rst = 1'b1;
    logic [7:0]  start_code = '0;
    logic [7:0]  step_count = '0;
    logic [23:0] step_dwell = '0;
    logic [31:0] idle_len = '0;
    logic [7:0]  ramp_code;
    logic        ramp_active;

    int checks = 0;
    int errors = 0;
    int nx_st, nx_s, nx_d, nx_n;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    chirp_ramp_gen u_chirp_ramp_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .soft_rst(soft_rst),
        .start_code(start_code), .step_count(step_count),
        .step_dwell(step_dwell), .idle_len(idle_len),
        .ramp_code(ramp_code), .ramp_active(ramp_active)
    );

    function automatic int sat_code(int st, int i);
        return (st + i > 255) ? 255 : st + i;
    endfunction

    function automatic int at_least_one(int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic chk(string tag, int ec, bit ea);
        checks++;
        if (ramp_code !== 8'(ec) || ramp_active !== ea) begin
            errors++;
            $display("FAIL %s code=%0d active=%0d expected code=%0d active=%0d",
                     tag, ramp_code, ramp_active, ec, ea);
        end
    endtask

    task automatic set_cfg(int st, int s, int d, int n);
        start_code = 8'(st);
        step_count = 8'(s);
        step_dwell = 24'(d);
        idle_len   = 32'(n);
    endtask

    // Walks one idle gap plus ramp, checking both outputs each cycle.
    // Called at a falling edge; returns at a falling edge.
    task automatic expect_chirp(int st, int s, int d, int n, int idle_code,
                                string idle_tag, int swap_at, int abort_at);
        int rc = 0;
        for (int i = 0; i < at_least_one(n); i++) begin
            #1 chk((i == 0) ? idle_tag : "R2", idle_code, 1'b0);
            @(negedge clk);
        end
        for (int k = 0; k <= s; k++) begin
            for (int j = 0; j < ((s == 0) ? 1 : at_least_one(d)); j++) begin
                string tag;
                if (s == 0) tag = "R6";
                else if (k == 0 && j == 0) tag = "R3";
                else if (st + k > 255) tag = "R7";
                else tag = "R4";
                #1 chk(tag, sat_code(st, k), 1'b1);
                if (rc == swap_at) set_cfg(nx_st, nx_s, nx_d, nx_n);
                if (rc == abort_at) begin
                    enable = 1'b0;
                    @(negedge clk);
                    return;
                end
                rc++;
                @(negedge clk);
            end
        end
    endtask

    task automatic restart(int st, int s, int d, int n);
        soft_rst = 1'b1;
        set_cfg(st, s, d, n);
        @(negedge clk);
        #1 chk("R1", 0, 1'b0);
        soft_rst = 1'b0;
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        @(negedge clk);
        @(negedge clk);
        #1 chk("R1", 0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        #1 chk("R1", 0, 1'b0);

        // Basic staircase, two chirps
        restart(10, 3, 2, 4);
        expect_chirp(10, 3, 2, 4, 0, "R10", -1, -1);
        expect_chirp(10, 3, 2, 4, 10, "R5", -1, -1);

        // Zero dwell and zero idle
        restart(100, 4, 0, 0);
        expect_chirp(100, 4, 0, 0, 0, "R10", -1, -1);
        expect_chirp(100, 4, 0, 0, 100, "R5", -1, -1);

        // Zero steps: one-cycle ramp
        restart(77, 0, 3, 2);
        expect_chirp(77, 0, 3, 2, 0, "R10", -1, -1);
        expect_chirp(77, 0, 3, 2, 77, "R5", -1, -1);

        // Saturation at the top code
        restart(250, 10, 1, 3);
        expect_chirp(250, 10, 1, 3, 0, "R10", -1, -1);
        expect_chirp(250, 10, 1, 3, 250, "R5", -1, -1);
        restart(255, 2, 2, 40);
        expect_chirp(255, 2, 2, 40, 0, "R10", -1, -1);

        // Mid-chirp configuration change takes effect afterwards (R9)
        restart(20, 5, 3, 2);
        nx_st = 60; nx_s = 2; nx_d = 1; nx_n = 5;
        expect_chirp(20, 5, 3, 2, 0, "R10", 4, -1);
        expect_chirp(60, 2, 1, 5, 20, "R9", -1, -1);
        expect_chirp(60, 2, 1, 5, 60, "R5", -1, -1);

        // Enable dropped mid-ramp
        restart(30, 6, 2, 3);
        expect_chirp(30, 6, 2, 3, 0, "R10", -1, 5);
        for (int i = 0; i < 4; i++) begin
            #1 chk("R8", 0, 1'b0);
            @(negedge clk);
        end
        enable = 1'b1;
        expect_chirp(30, 6, 2, 3, 0, "R8", -1, -1);

        // Constrained random configurations
        for (int t = 0; t < 12; t++) begin
            int st, s, d, n;
            st = $urandom_range(0, 255);
            s  = $urandom_range(0, 12);
            d  = $urandom_range(0, 4);
            n  = $urandom_range(0, 6);
            restart(st, s, d, n);
            expect_chirp(st, s, d, n, 0, "R10", -1, -1);
            expect_chirp(st, s, d, n, st, "R5", -1, -1);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule